// File: doc/BRIEF.md
# Interrupt Status and Mask Register

This block is a single 16-bit register that a host reads and writes over a plain strobe interface. Its low byte shows the state of seven event sources. Its high byte holds one enable bit per source. Six of the sources are caught on their rising edge and held until the host reads the register. The seventh source, a FIFO service request, is shown at its live level so that software can poll it. A single interrupt pin is asserted whenever an enabled status bit is set, and an input selects whether that pin is active-low or active-high.

A read returns the register as it stands in the read cycle. At the clock edge that closes that cycle, the captured bits are cleared. If a new rising edge arrives in the same cycle as the read, the bit stays set, so no event is lost between reading and clearing. Host writes change only the enable bits.

Top module: `irq_status_reg`

## Requirements
- R1: Read data layout: bit 0 CCIR stream error, bit 1 statistics ready, bit 2 last code, bit 3 FIFO service request, bit 4 FIFO error, bit 5 FIFO stop, bit 6 memory error. Bits 14..8 are the enables for those sources in the same order (bit 8 enables bit 0). Bits 7 and 15 always read 0.
- R2: After reset every status bit and every enable bit is 0, and the interrupt pin is inactive.
- R3: A captured bit (every source except bit 3) is set in the cycle after its input goes from 0 to 1. An input that stays high does not set the bit again after it has been cleared.
- R4: A cycle with `rd_en` high returns the current status and enables on `rd_data`. At the end of that cycle every captured bit is cleared.
- R5: Bit 3 always equals the live level of `evt_lvl[3]` and is not changed by reads.
- R6: A cycle with `wr_en` high loads `wr_data[14:8]` into the enables. Writing `wr_data[6:0]` has no effect on the status bits.
- R7: The interrupt is asserted when any status bit and its enable bit are both 1.
- R8: With `irq_pol_high`=0 the asserted level of `irq_out` is 0. With `irq_pol_high`=1 it is 1.
- R9: A rising edge in the same cycle as a read leaves that captured bit set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Register read strobe; clears the captured bits at the end of the cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; only bits 14..8 are used |
| evt_lvl | input | 7 | Event source levels, one per status bit |
| irq_pol_high | input | 1 | 1 = interrupt pin active-high, 0 = active-low |
| rd_data | output | 16 | Register contents, combinational from current state |
| irq_out | output | 1 | Interrupt pin |

## Verification
A wrong enable or captured bit appears on `rd_data` in the very next cycle, because the register contents are driven combinationally. A wrong interrupt level appears on `irq_out` in that same cycle. A lost clear, or an edge detector that re-arms on a held level, shows as a bit that stays set in the cycle after a read. A swallowed event shows as a bit still 0 one cycle after a read that coincided with an edge. The stimulus table walks each of these sequences, and each step compares the full 16-bit word and the pin level.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int IRQ_REG_W  = 16;
   localparam int IRQ_SRC_N  = 7;
   localparam int IRQ_EN_LSB = IRQ_REG_W / 2;

   // Source positions in the status byte; decoded by software, so fixed.
   localparam int SRC_CCIR_ERR = 0;
   localparam int SRC_STAT_RDY = 1;
   localparam int SRC_LAST_CODE = 2;
   localparam int SRC_FIFO_REQ = 3;
   localparam int SRC_FIFO_ERR = 4;
   localparam int SRC_FIFO_STOP = 5;
   localparam int SRC_MEM_ERR  = 6;

   // Sources shown at their live level rather than captured.
   localparam logic [IRQ_SRC_N-1:0] IRQ_LEVEL_SRC = IRQ_SRC_N'(1) << SRC_FIFO_REQ;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   logic [N-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int           N          = 7,
   parameter logic [N-1:0] LEVEL_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] rise,
   input  logic         clr,
   output logic [N-1:0] status
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      if (LEVEL_MASK[i]) begin : g_level
         assign status[i] = lvl[i];
         logic unused_rise;
         assign unused_rise = rise[i];
      end else begin : g_sticky
         logic held;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held <= 1'b0;
            else        held <= (held & ~clr) | rise[i];
         end
         assign status[i] = held;
      end
   end
endmodule

// File: rtl/irq_output.sv
module irq_output #(
   parameter int N = 7
) (
   input  logic [N-1:0] status,
   input  logic [N-1:0] enable,
   input  logic         pol_high,
   output logic         irq
);
   logic any_hit;
   assign any_hit = |(status & enable);
   assign irq     = pol_high ? any_hit : ~any_hit;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import irq_pkg::*;
#(
   parameter int                   REG_W      = IRQ_REG_W,
   parameter int                   SRC_N      = IRQ_SRC_N,
   parameter logic [SRC_N-1:0]     LEVEL_MASK = IRQ_LEVEL_SRC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic [SRC_N-1:0] evt_lvl,
   input  logic             irq_pol_high,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_out
);
   localparam int EN_LSB = REG_W / 2;
   localparam int EN_MSB = EN_LSB + SRC_N - 1;

   if (REG_W % 2 != 0) begin : g_bad_width
      $error("irq_status_reg: REG_W must be even");
   end
   if (SRC_N >= EN_LSB) begin : g_bad_count
      $error("irq_status_reg: SRC_N must leave a reserved bit in each half");
   end

   logic [SRC_N-1:0] rise;
   logic [SRC_N-1:0] status;
   logic [SRC_N-1:0] enable_q;

   irq_edge_detect #(.N(SRC_N)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (evt_lvl),
      .rise (rise)
   );

   irq_status_bank #(.N(SRC_N), .LEVEL_MASK(LEVEL_MASK)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (evt_lvl),
      .rise  (rise),
      .clr   (rd_en),
      .status(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     enable_q <= '0;
      else if (wr_en) enable_q <= wr_data[EN_MSB:EN_LSB];
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data[EN_LSB-1:0], wr_data[REG_W-1:EN_MSB+1]};

   always_comb begin
      rd_data                  = '0;
      rd_data[SRC_N-1:0]       = status;
      rd_data[EN_MSB:EN_LSB]   = enable_q;
   end

   irq_output #(.N(SRC_N)) u_out (
      .status  (status),
      .enable  (enable_q),
      .pol_high(irq_pol_high),
      .irq     (irq_out)
   );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
   parameter int               REG_W      = 16,
   parameter int               SRC_N      = 7,
   parameter logic [SRC_N-1:0] LEVEL_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [SRC_N-1:0] evt_lvl,
   input logic             irq_pol_high,
   input logic [REG_W-1:0] rd_data,
   input logic             irq_out
);
   localparam int EN_LSB = REG_W / 2;
   localparam int EN_MSB = EN_LSB + SRC_N - 1;

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   for (genvar k = 0; k < SRC_N; k++) begin : g_src
      if (LEVEL_MASK[k]) begin : g_lvl
         p_level_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_data[k] == evt_lvl[k]);
      end else begin : g_stk
         p_set_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && evt_lvl[k] && !$past(evt_lvl[k]) |=> rd_data[k]);
         p_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && rd_en && !(evt_lvl[k] && !$past(evt_lvl[k])) |=> !rd_data[k]);
         p_keep_on_coincide_r9: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && rd_en && evt_lvl[k] && !$past(evt_lvl[k]) |=> rd_data[k]);
      end
   end

   p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[EN_LSB-1] && !rd_data[REG_W-1]);

   p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[EN_MSB:EN_LSB] == $past(wr_data[EN_MSB:EN_LSB]));

   p_irq_level_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (irq_pol_high ? (|(rd_data[SRC_N-1:0] & rd_data[EN_MSB:EN_LSB]))
                               : !(|(rd_data[SRC_N-1:0] & rd_data[EN_MSB:EN_LSB]))));
endmodule

bind irq_status_reg irq_status_chk #(
   .REG_W(REG_W), .SRC_N(SRC_N), .LEVEL_MASK(LEVEL_MASK)
) u_chk (.*);

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [6:0]  evt_lvl = '0;
   logic        irq_pol_high = 1'b0;
   logic [15:0] rd_data;
   logic        irq_out;

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   irq_status_reg dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .evt_lvl(evt_lvl), .irq_pol_high(irq_pol_high),
      .rd_data(rd_data), .irq_out(irq_out)
   );

   typedef struct packed {
      logic [6:0]  evt;
      logic        rd;
      logic        wr;
      logic [15:0] wd;
      logic        pol;
      logic [15:0] exp_rd;
      logic        exp_irq;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{7'h00, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 8'd2},
      '{7'h00, 1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 8'd6},
      '{7'h01, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h7F00, 1'b1, 8'd1},
      '{7'h01, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h7F01, 1'b0, 8'd3},
      '{7'h01, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h7F01, 1'b0, 8'd4},
      '{7'h01, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h7F00, 1'b1, 8'd3},
      '{7'h08, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h7F08, 1'b0, 8'd5},
      '{7'h08, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h7F08, 1'b0, 8'd5},
      '{7'h08, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h7F08, 1'b1, 8'd8},
      '{7'h00, 1'b0, 1'b1, 16'h00FF, 1'b1, 16'h7F00, 1'b0, 8'd8},
      '{7'h40, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h0000, 1'b0, 8'd6},
      '{7'h40, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0040, 1'b0, 8'd7},
      '{7'h00, 1'b0, 1'b1, 16'h4000, 1'b1, 16'h0000, 1'b0, 8'd4},
      '{7'h40, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h4000, 1'b0, 8'd9},
      '{7'h40, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h4040, 1'b1, 8'd9},
      '{7'h77, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h4040, 1'b1, 8'd7},
      '{7'h77, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h4077, 1'b1, 8'd1},
      '{7'h77, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h4077, 1'b1, 8'd4},
      '{7'h77, 1'b0, 1'b0, 16'h0000, 1'b1, 16'h4000, 1'b0, 8'd4}
   };

   task automatic check(input logic [15:0] exp_rd, input logic exp_irq, input int req);
      n_checks++;
      if (rd_data !== exp_rd || irq_out !== exp_irq) begin
         n_fail++;
         $display("FAIL R%0d: rd_data=%h irq_out=%b expected rd_data=%h irq_out=%b",
                  req, rd_data, irq_out, exp_rd, exp_irq);
      end
   endtask

   initial begin
      // Reset state, R2
      repeat (3) @(negedge clk);
      #5 check(16'h0000, 1'b1, 2);   // R2 during reset
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         evt_lvl      = VECS[i].evt;
         rd_en        = VECS[i].rd;
         wr_en        = VECS[i].wr;
         wr_data      = VECS[i].wd;
         irq_pol_high = VECS[i].pol;
         #5 check(VECS[i].exp_rd, VECS[i].exp_irq, int'(VECS[i].req));
      end
      // R8: polarity flip alone changes only the pin level
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0; evt_lvl = 7'h08; irq_pol_high = 1'b0;
      #5 check(16'h4008, 1'b1, 8);   // R8 mask bit3 off: inactive high
      // R6: write to status bits only; enables set to zero
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h007F; evt_lvl = 7'h00;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 16'h0000;
      #5 check(16'h0000, 1'b1, 6);   // R6 status unchanged by write
      // R2: mid-run reset clears enables and captured bits
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h7F00; evt_lvl = 7'h02;
      @(negedge clk);
      wr_en = 1'b0;
      #5 check(16'h7F02, 1'b0, 3);   // R3 bit1 captured
      evt_lvl = 7'h00;
      rst_n = 1'b0;
      #1 check(16'h0000, 1'b1, 2);   // R2 reset clears all
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5 check(16'h0000, 1'b1, 2);   // R2 after release
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #200000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule